// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block is a small, fully associative cache of address translations. A lookup presents a virtual page number, a process identifier, a page offset and a read/write flag. Every stored entry is compared in parallel, and in the same cycle the block returns a hit or a miss and the physical address. It also flags a write-protection fault when a write lands on a page that may not be written. Each entry's tag includes the process identifier, so translations from different processes can live side by side and a context switch needs no flush.

A successful lookup marks the entry as referenced, and a permitted write also marks it dirty. A miss tells the requester to fetch the translation elsewhere, install it through the fill stream and retry the access. Fills go to the lowest-numbered empty slot when one exists. Otherwise they go to a slot named by a free-running pseudo-random sequence. When a fill displaces a valid entry, an eviction record carrying that entry's page number, process identifier and reference and dirty bits is offered on an output stream so that the bits can be copied back.

Both streams use valid/ready handshakes. A transfer happens on a clock edge where valid and ready are both high. The eviction stream holds its record stable until it is taken. While a record is waiting and the consumer is not ready, the fill stream is not ready either, so no record can ever be overwritten. A global invalidate pin empties the table.

Top module: `pid_tlb`

## Requirements
- R1: After reset every slot is empty: any lookup misses, `ev_valid` is low and `fill_ready` is high.
- R2: A lookup hits when a valid entry holds the same page number and the same process identifier. In that same cycle `lk_paddr` equals the entry's physical page number concatenated above the page offset, with the offset in the low 12 bits.
- R3: An entry whose page number matches but whose process identifier differs does not hit.
- R4: `lk_miss` is high exactly when `lk_valid` is high and no entry hits. With `lk_valid` low, both `lk_hit` and `lk_miss` are low.
- R5: A write that hits an entry installed with `fill_wr_ok` low raises `lk_wfault` in the same cycle and leaves that entry's dirty and reference bits unchanged.
- R6: On the clock edge after a hit without a fault, the entry's reference bit is set. If the hit was a write, its dirty bit is also set.
- R7: A fill goes to the lowest-numbered empty slot when any slot is empty, and no eviction record is produced. A newly installed entry starts with reference and dirty bits clear.
- R8: When the table is full, the fill slot is the value of a 4-bit LFSR (width log2 of the entry count). The LFSR is set to 0001 by reset and steps on every clock as next = {s[2:0], s[3]^s[2]}, so it never reaches zero.
- R9: When a fill displaces a valid entry, on the next cycle `ev_valid` is high and `ev_vpn`, `ev_pid`, `ev_ref` and `ev_dirty` carry the displaced entry's values as they were before the fill.
- R10: While `ev_valid` is high and `ev_ready` is low, the record stays stable and `fill_ready` is low. A fill offered during that time is not installed.
- R11: Asserting `inv_all` for one cycle empties every slot at the next edge. `fill_ready` is low in that cycle, and no eviction records are produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_offset | input | 12 | Page offset |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed |
| lk_wfault | output | 1 | Write to a write-protected page |
| lk_paddr | output | 30 | Physical address |
| fill_valid | input | 1 | Fill stream valid |
| fill_ready | output | 1 | Fill stream ready |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pid | input | 8 | Fill process identifier |
| fill_ppn | input | 18 | Fill physical page number |
| fill_wr_ok | input | 1 | Fill entry permits writes |
| ev_valid | output | 1 | Eviction record valid |
| ev_ready | input | 1 | Eviction consumer ready |
| ev_vpn | output | 20 | Displaced page number |
| ev_pid | output | 8 | Displaced process identifier |
| ev_ref | output | 1 | Displaced reference bit |
| ev_dirty | output | 1 | Displaced dirty bit |

## Verification
The bench builds the block with its default parameters: 16 entries, 20/8/18/12-bit fields and a 4-bit LFSR. With only 16 slots, the table fills within a few fills, so the random-victim path is reached early. A run of more than 15 full-table fills walks the LFSR's whole period and lands evictions on slots whose bits were set, left clear or protected by earlier lookups. The all-ones and all-zero page numbers, process identifiers and offsets are used, which exercises the ends of the field widths.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int MAX_LFSR_W = 8;

  // Maximal-length Fibonacci step, shifting toward the MSB.
  function automatic logic [7:0] lfsr_step(input logic [7:0] s, input int w);
    logic       fb;
    logic [8:0] m;
    case (w)
      2:       fb = s[1] ^ s[0];
      3:       fb = s[2] ^ s[1];
      4:       fb = s[3] ^ s[2];
      5:       fb = s[4] ^ s[2];
      6:       fb = s[5] ^ s[4];
      7:       fb = s[6] ^ s[5];
      default: fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    endcase
    m = (9'd1 << w) - 9'd1;
    return ({s[6:0], 1'b0} | {7'd0, fb}) & m[7:0];
  endfunction
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  import tlb_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= W'(1);
    else        state <= W'(lfsr_step(8'(state), W));
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R8
endmodule

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W = 20,
  parameter int PID_W = 8,
  parameter int PPN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic             load,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PID_W-1:0] ld_pid,
  input  logic [PPN_W-1:0] ld_ppn,
  input  logic             ld_wr_ok,
  input  logic             touch,
  input  logic             touch_wr,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  output logic             match,
  output logic             e_valid,
  output logic             e_ref,
  output logic             e_dirty,
  output logic             e_wr_ok,
  output logic [VPN_W-1:0] e_vpn,
  output logic [PID_W-1:0] e_pid,
  output logic [PPN_W-1:0] e_ppn
);
  assign match = e_valid && (e_vpn == lk_vpn) && (e_pid == lk_pid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_ref   <= 1'b0;
      e_dirty <= 1'b0;
      e_wr_ok <= 1'b0;
      e_vpn   <= '0;
      e_pid   <= '0;
      e_ppn   <= '0;
    end else if (inv) begin
      e_valid <= 1'b0;
    end else if (load) begin
      e_valid <= 1'b1;
      e_ref   <= 1'b0;
      e_dirty <= 1'b0;
      e_wr_ok <= ld_wr_ok;
      e_vpn   <= ld_vpn;
      e_pid   <= ld_pid;
      e_ppn   <= ld_ppn;
    end else if (touch) begin
      e_ref <= 1'b1;
      if (touch_wr) e_dirty <= 1'b1;
    end
  end

  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    load && !inv |=> e_valid && !e_ref && !e_dirty); // R7
  AST_INV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> !e_valid); // R11
  AST_TOUCH_REF: assert property (@(posedge clk) disable iff (!rst_n)
    touch && !load && !inv |=> e_ref); // R6
  AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    match && lk_write && !e_wr_ok && !load && !inv |=> $stable(e_dirty) && $stable(e_ref)); // R5
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   rand_idx,
  output logic [IDX_W-1:0]   victim
);
  logic             free_found;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim = free_found ? free_idx : rand_idx;

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid) |-> !valid[victim]); // R7
endmodule

// File: rtl/pid_tlb.sv
module pid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [PID_W-1:0] lk_pid,
  input  logic             lk_write,
  input  logic [OFF_W-1:0] lk_offset,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_wfault,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [VPN_W-1:0] ev_vpn,
  output logic [PID_W-1:0] ev_pid,
  output logic             ev_ref,
  output logic             ev_dirty
);
  logic [ENTRIES-1:0] match, e_valid, e_ref, e_dirty, e_wr_ok, load, touch;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PID_W-1:0]   e_pid [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [IDX_W-1:0]   rand_idx, victim;
  logic [PPN_W-1:0]   ppn_sel;
  logic               wr_ok_sel, any_match, fill_fire, capture;

  tlb_lfsr #(.W(IDX_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rand_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(e_valid), .rand_idx(rand_idx), .victim(victim)
  );

  assign fill_ready = !inv_all && (!ev_valid || ev_ready);
  assign fill_fire  = fill_valid && fill_ready;
  assign capture    = fill_fire && e_valid[victim];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign load[g]  = fill_fire && (victim == IDX_W'(g));
    assign touch[g] = lk_valid && match[g] && !(lk_write && !e_wr_ok[g]);

    tlb_entry #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .inv(inv_all), .load(load[g]),
      .ld_vpn(fill_vpn), .ld_pid(fill_pid), .ld_ppn(fill_ppn), .ld_wr_ok(fill_wr_ok),
      .touch(touch[g]), .touch_wr(lk_write),
      .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_write(lk_write),
      .match(match[g]), .e_valid(e_valid[g]), .e_ref(e_ref[g]), .e_dirty(e_dirty[g]),
      .e_wr_ok(e_wr_ok[g]), .e_vpn(e_vpn[g]), .e_pid(e_pid[g]), .e_ppn(e_ppn[g])
    );
  end

  // One-hot OR mux over the match vector.
  always_comb begin
    ppn_sel   = '0;
    wr_ok_sel = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        ppn_sel   = ppn_sel | e_ppn[i];
        wr_ok_sel = wr_ok_sel | e_wr_ok[i];
      end
    end
  end

  assign any_match = |match;
  assign lk_hit    = lk_valid && any_match;
  assign lk_miss   = lk_valid && !any_match;
  assign lk_wfault = lk_hit && lk_write && !wr_ok_sel;
  assign lk_paddr  = {ppn_sel, lk_offset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_vpn   <= '0;
      ev_pid   <= '0;
      ev_ref   <= 1'b0;
      ev_dirty <= 1'b0;
    end else if (capture) begin
      ev_valid <= 1'b1;
      ev_vpn   <= e_vpn[victim];
      ev_pid   <= e_pid[victim];
      ev_ref   <= e_ref[victim];
      ev_dirty <= e_dirty[victim];
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R4
  AST_EV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_vpn) && $stable(ev_pid)
      && $stable(ev_ref) && $stable(ev_dirty)); // R10
  AST_INV_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> e_valid == '0); // R11
  AST_FAULT_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_wfault |-> lk_valid && lk_write && (touch == '0)); // R5
endmodule

// File: tb/pid_tlb_bench.sv
`timescale 1ns/1ps
module pid_tlb_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_pid = '0;
  logic [11:0] lk_offset = '0;
  logic        lk_hit, lk_miss, lk_wfault;
  logic [29:0] lk_paddr;
  logic        fill_valid = 1'b0, fill_ready, fill_wr_ok = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic [17:0] fill_ppn = '0;
  logic        ev_valid, ev_ready = 1'b1, ev_ref, ev_dirty;
  logic [19:0] ev_vpn;
  logic [7:0]  ev_pid;

  always #2 clk = ~clk;

  pid_tlb u_pid_tlb (.*);

  int nvec = 0, nfail = 0;

  // Scoreboard model
  logic        m_v [N], m_wr [N], m_ref [N], m_dirty [N];
  logic [19:0] m_vpn [N];
  logic [7:0]  m_pid [N];
  logic [17:0] m_ppn [N];
  logic [3:0]  m_lfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 4'd1;
    else        m_lfsr <= {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};  // R8
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find(input logic [19:0] v, input logic [7:0] p);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == v && m_pid[i] == p) return i;
    return -1;
  endfunction

  task automatic lookup(input logic [19:0] v, input logic [7:0] p, input logic w,
                        input logic [11:0] off, input bit eh, input bit ef,
                        input logic [17:0] eppn, input string req);
    int s;
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_write = w; lk_offset = off;
    #1;
    chk(lk_hit == eh, {req, " hit"}, 64'(lk_hit), 64'(eh));
    chk(lk_miss == !eh, {req, " miss"}, 64'(lk_miss), 64'(!eh));
    chk(lk_wfault == ef, {req, " wfault"}, 64'(lk_wfault), 64'(ef));
    if (eh) chk(lk_paddr == {eppn, off}, {req, " paddr"}, 64'(lk_paddr), 64'({eppn, off}));
    s = find(v, p);
    if (s >= 0 && !(w && !m_wr[s])) begin
      m_ref[s] = 1'b1;
      if (w) m_dirty[s] = 1'b1;
    end
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic lookup_m(input logic [19:0] v, input logic [7:0] p, input string req);
    int s;
    s = find(v, p);
    lookup(v, p, 1'b0, 12'h5A5, s >= 0, 1'b0, (s >= 0) ? m_ppn[s] : 18'd0, req);
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] p, input logic [17:0] pp, input logic w);
    int  slot;
    bit  ev_exp;
    logic [19:0] xv; logic [7:0] xp; logic xr, xd;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R10 fill_ready", 64'(fill_ready), 64'd1);
    slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) slot = int'(m_lfsr);  // R8
    ev_exp = m_v[slot];
    xv = m_vpn[slot]; xp = m_pid[slot]; xr = m_ref[slot]; xd = m_dirty[slot];
    fill_valid = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_wr_ok = w;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(ev_valid == ev_exp, "R7/R9 ev_valid", 64'(ev_valid), 64'(ev_exp));
    if (ev_exp) begin
      chk(ev_vpn == xv, "R9 ev_vpn", 64'(ev_vpn), 64'(xv));
      chk(ev_pid == xp, "R9 ev_pid", 64'(ev_pid), 64'(xp));
      chk(ev_ref == xr, "R6/R9 ev_ref", 64'(ev_ref), 64'(xr));
      chk(ev_dirty == xd, "R5/R6/R9 ev_dirty", 64'(ev_dirty), 64'(xd));
    end
    m_v[slot] = 1'b1; m_vpn[slot] = v; m_pid[slot] = p; m_ppn[slot] = pp;
    m_wr[slot] = w; m_ref[slot] = 1'b0; m_dirty[slot] = 1'b0;
  endtask

  typedef struct packed {
    logic [19:0] vpn; logic [7:0] pid; logic wr; logic [11:0] off;
    logic eh; logic ef; logic [17:0] ppn;
  } vec_t;

  localparam vec_t VT [10] = '{
    '{20'h00010, 8'h01, 1'b0, 12'h123, 1'b1, 1'b0, 18'h00A00},  // R2
    '{20'h00010, 8'h02, 1'b1, 12'hFFF, 1'b1, 1'b0, 18'h00B00},  // R2 R3 same vpn other pid
    '{20'h00010, 8'h03, 1'b0, 12'h000, 1'b0, 1'b0, 18'h00000},  // R3
    '{20'h00011, 8'h01, 1'b1, 12'h010, 1'b1, 1'b1, 18'h00A01},  // R5
    '{20'hFFFFF, 8'hFF, 1'b1, 12'hABC, 1'b1, 1'b0, 18'h3FFFF},  // R2 all ones
    '{20'h00000, 8'h00, 1'b0, 12'h000, 1'b1, 1'b0, 18'h00000},  // R2 all zero
    '{20'h12345, 8'h07, 1'b0, 12'h456, 1'b1, 1'b0, 18'h2ABCD},  // R2
    '{20'h12346, 8'h07, 1'b0, 12'h456, 1'b0, 1'b0, 18'h00000},  // R4
    '{20'h00010, 8'h01, 1'b1, 12'h777, 1'b1, 1'b0, 18'h00A00},  // R6 dirty
    '{20'h12345, 8'h07, 1'b1, 12'h001, 1'b1, 1'b1, 18'h2ABCD}   // R5
  };

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_wr[i] = 0; m_ref[i] = 0; m_dirty[i] = 0;
      m_vpn[i] = '0; m_pid[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(ev_valid == 1'b0, "R1 ev_valid", 64'(ev_valid), 64'd0);
    chk(fill_ready == 1'b1, "R1 fill_ready", 64'(fill_ready), 64'd1);
    chk(lk_hit == 1'b0 && lk_miss == 1'b0, "R4 idle lookup", 64'({lk_hit, lk_miss}), 64'd0);
    lookup(20'h00000, 8'h00, 1'b0, 12'h000, 1'b0, 1'b0, 18'd0, "R1");

    // R7 placement into free slots 0..5
    fill(20'h00010, 8'h01, 18'h00A00, 1'b1);
    fill(20'h00011, 8'h01, 18'h00A01, 1'b0);
    fill(20'h00010, 8'h02, 18'h00B00, 1'b1);
    fill(20'hFFFFF, 8'hFF, 18'h3FFFF, 1'b1);
    fill(20'h00000, 8'h00, 18'h00000, 1'b1);
    fill(20'h12345, 8'h07, 18'h2ABCD, 1'b0);

    foreach (VT[k]) begin
      string tag;
      tag = !VT[k].eh ? "R3/R4" : (VT[k].ef ? "R5" : "R2");
      lookup(VT[k].vpn, VT[k].pid, VT[k].wr, VT[k].off, VT[k].eh, VT[k].ef, VT[k].ppn, tag);
    end

    for (int i = 6; i < N; i++) fill(20'h40000 + 20'(i), 8'h09, 18'(i), 1'b1);
    lookup(20'h40007, 8'h09, 1'b1, 12'h0F0, 1'b1, 1'b0, 18'd7, "R2 R6");
    lookup(20'h4000C, 8'h09, 1'b0, 12'h0F0, 1'b1, 1'b0, 18'd12, "R2 R6");

    // R8 R9 random replacement with eviction records
    for (int k = 0; k < 20; k++) begin
      fill(20'h50000 + 20'(k), 8'h0A, 18'h10000 + 18'(k), 1'(k));
      if (k % 3 == 0) lookup_m(20'h50000 + 20'(k), 8'h0A, "R2 R6");
    end

    // R10 back-pressure
    @(negedge clk);
    ev_ready = 1'b0;
    fill(20'h60000, 8'h0B, 18'h00111, 1'b1);
    begin
      logic [19:0] hv; logic [7:0] hp;
      hv = ev_vpn; hp = ev_pid;
      fill_valid = 1'b1; fill_vpn = 20'h60001; fill_pid = 8'h0B; fill_ppn = 18'h222; fill_wr_ok = 1'b1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(fill_ready == 1'b0, "R10 fill_ready low", 64'(fill_ready), 64'd0);
        chk(ev_valid && ev_vpn == hv && ev_pid == hp, "R10 record held", 64'(ev_vpn), 64'(hv));
      end
      fill_valid = 1'b0;
      ev_ready = 1'b1;
      @(negedge clk);
      chk(ev_valid == 1'b0, "R10 record taken", 64'(ev_valid), 64'd0);
    end
    lookup_m(20'h60001, 8'h0B, "R10 not installed");
    lookup_m(20'h60000, 8'h0B, "R10 installed");

    // R11 invalidate
    @(negedge clk);
    inv_all = 1'b1;
    #1;
    chk(fill_ready == 1'b0, "R11 fill_ready", 64'(fill_ready), 64'd0);
    @(negedge clk);
    inv_all = 1'b0;
    chk(ev_valid == 1'b0, "R11 no record", 64'(ev_valid), 64'd0);
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    lookup(20'h60000, 8'h0B, 1'b0, 12'h0, 1'b0, 1'b0, 18'd0, "R11");
    lookup(20'h00010, 8'h01, 1'b0, 12'h0, 1'b0, 1'b0, 18'd0, "R11");
    fill(20'h70000, 8'h0C, 18'h00333, 1'b1);
    lookup(20'h70000, 8'h0C, 1'b0, 12'h321, 1'b1, 1'b0, 18'h00333, "R7 R2");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule